// File: doc/BRIEF.md
# Per-Second Sample Averaging and Totalizing Unit

This block post-processes a stream of 8-bit converter samples. Every sample strobe adds the sample into a per-second sum. In offset mode the sample is read as a signed value around mid-scale (128). Readings above mid-scale add their magnitude to a positive sum, and readings below it add their magnitude to a negative sum. A once-per-second tick closes the current second. Each sum is scaled down by 64 into a 14-bit average, and the averages are then added into two 32-bit running totals that the host can overwrite. The block also shows the last sample taken and the smallest and largest raw samples seen since reset.

A small controller sequences each second through four named states:
- `ST_OFF`: the unit is disabled, or it has just been enabled.
- `ST_ACCUM`: samples are being summed.
- `ST_LATCH`: the sums are moved into the averages and a new second starts.
- `ST_ADD`: the averages are added into the totals.

The transitions are:
- any state to `ST_OFF` when enable is low;
- `ST_OFF` to `ST_ACCUM` when enable is high;
- `ST_ACCUM` to `ST_LATCH` on a tick;
- `ST_LATCH` to `ST_ADD` unconditionally;
- `ST_ADD` to `ST_ACCUM` unconditionally.

The sample-rate timer that paces the strobe is outside this block. That timer must keep the rate at or below 4000 samples per second so that a full second of samples fits the 20-bit sums.

Top module: `adc_avg_accum`

## Requirements
- R1: After reset both averages, both totals and the last-sample output read 0, the minimum reads 0xFF and the maximum reads 0x00.
- R2: With the offset bit clear, each accepted sample adds its raw unsigned value to the positive sum, and the negative sum does not grow.
- R3: With the offset bit set, a sample above 128 adds (sample − 128) to the positive sum, a sample below 128 adds (128 − sample) to the negative sum, and a sample equal to 128 adds nothing.
- R4: A tick seen in `ST_ACCUM` loads each average with its sum shifted right by 6 (bits 19:6) on the next clock. A sample accepted in that same clock starts the new second's sum. A sample accepted in the tick cycle itself belongs to the closing second.
- R5: A per-second sum saturates at 0xFFFFF and does not wrap.
- R6: One clock after the averages load, the positive average is added to the positive total and the negative average to the negative total, modulo 2^32.
- R7: With the group bit set, both averages are added into the positive total and the negative total is left unchanged.
- R8: With the stop bit set, neither total accumulates, while the last sample, the extremes, the sums and the averages keep updating.
- R9: A host write (select 0 = positive total, 1 = negative total) loads the selected total on the next clock and takes priority over accumulation into that total in the same clock.
- R10: Every accepted sample updates the last-sample output, and it lowers the minimum or raises the maximum using the raw 8-bit value in either mode.
- R11: With enable low, samples and ticks are ignored and both sums clear to 0. The last sample, the extremes, the averages and the totals hold.
- R12: A tick that arrives while in `ST_LATCH` or `ST_ADD` is ignored, so each accepted tick adds into the totals exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Unit enable |
| cfg_ofs | input | 1 | Signed mid-scale offset mode |
| cfg_grp | input | 1 | Route both averages into the positive total |
| cfg_stp | input | 1 | Freeze the totals |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 8 | Sample value |
| sec_tick | input | 1 | One-second tick, one clock wide |
| tot_wr_en | input | 1 | Host write strobe for a total |
| tot_wr_sel | input | 1 | Total to write: 0 positive, 1 negative |
| tot_wr_data | input | 32 | Value to write into the selected total |
| inst_smp | output | 8 | Last accepted sample |
| avg_pos | output | 14 | Positive average of the last second |
| avg_neg | output | 14 | Negative average of the last second |
| tot_pos | output | 32 | Positive running total |
| tot_neg | output | 32 | Negative running total |
| smp_min | output | 8 | Smallest raw sample seen |
| smp_max | output | 8 | Largest raw sample seen |

## Verification
The first pattern is an unsigned burst of mixed values, which shows the plain path from the sum through the shift to the total. A long burst of full-scale samples then shows whether the sum saturates or wraps. A repeated signed set holding 0, 128, 255 and values on both sides of mid-scale separates positive from negative steering and shows that mid-scale is dropped. The same set is replayed under the group and stop bits, under host writes (one of them in the adding cycle), under back-to-back ticks and with the unit disabled, to tell the routing, priority and ignore rules apart.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ACCUM = 2'd1,
        ST_LATCH = 2'd2,
        ST_ADD   = 2'd3
    } acc_state_e;
endpackage

// File: rtl/adc_steer.sv
module adc_steer #(
    parameter int SMP_W = 8
) (
    input  logic             ofs,
    input  logic             take,
    input  logic [SMP_W-1:0] smp,
    output logic [SMP_W-1:0] mag_pos,
    output logic [SMP_W-1:0] mag_neg
);
    localparam logic [SMP_W-1:0] MID = {1'b1, {(SMP_W-1){1'b0}}};

    always_comb begin
        mag_pos = '0;
        mag_neg = '0;
        if (take) begin
            if (!ofs) begin
                mag_pos = smp;
            end else if (smp > MID) begin
                mag_pos = {1'b0, smp[SMP_W-2:0]};
            end else if (smp < MID) begin
                mag_neg = MID - smp;
            end
        end
    end
endmodule

// File: rtl/adc_sec_sum.sv
module adc_sec_sum #(
    parameter int SMP_W = 8,
    parameter int SUM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SMP_W-1:0] add_val,
    output logic [SUM_W-1:0] sum_q
);
    logic [SUM_W:0]   wide;
    logic [SUM_W-1:0] ext_val;

    assign ext_val = {{(SUM_W-SMP_W){1'b0}}, add_val};
    assign wide    = {1'b0, sum_q} + {1'b0, ext_val};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (!run) begin
            sum_q <= '0;
        end else if (restart) begin
            sum_q <= ext_val;
        end else if (wide[SUM_W]) begin
            sum_q <= '1;
        end else begin
            sum_q <= wide[SUM_W-1:0];
        end
    end

    // R5: while summing, the sum never falls (it saturates rather than wraps)
    assert_sum_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |=> (sum_q >= $past(sum_q)));
endmodule

// File: rtl/adc_total.sv
module adc_total #(
    parameter int AVG_W = 14,
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TOT_W-1:0] wr_data,
    input  logic             add_en,
    input  logic [AVG_W-1:0] add_a,
    input  logic [AVG_W-1:0] add_b,
    output logic [TOT_W-1:0] tot_q
);
    logic [TOT_W-1:0] inc;

    assign inc = {{(TOT_W-AVG_W){1'b0}}, add_a} + {{(TOT_W-AVG_W){1'b0}}, add_b};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tot_q <= '0;
        end else if (wr_en) begin
            tot_q <= wr_data;
        end else if (add_en) begin
            tot_q <= tot_q + inc;
        end
    end
endmodule

// File: rtl/adc_extrema.sv
module adc_extrema #(
    parameter int SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [SMP_W-1:0] smp,
    output logic [SMP_W-1:0] last_q,
    output logic [SMP_W-1:0] min_q,
    output logic [SMP_W-1:0] max_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            min_q  <= '1;
            max_q  <= '0;
        end else if (take) begin
            last_q <= smp;
            if (smp < min_q) min_q <= smp;
            if (smp > max_q) max_q <= smp;
        end
    end

    // R10: once any sample is seen the minimum never exceeds the maximum
    assert_extrema_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (min_q <= max_q) || (min_q == '1 && max_q == '0));
endmodule

// File: rtl/adc_avg_accum.sv
module adc_avg_accum
    import adc_avg_pkg::*;
#(
    parameter int SMP_W     = 8,
    parameter int SUM_W     = 20,
    parameter int AVG_SHIFT = 6,
    parameter int TOT_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_en,
    input  logic                         cfg_ofs,
    input  logic                         cfg_grp,
    input  logic                         cfg_stp,
    input  logic                         smp_vld,
    input  logic [SMP_W-1:0]             smp_data,
    input  logic                         sec_tick,
    input  logic                         tot_wr_en,
    input  logic                         tot_wr_sel,
    input  logic [TOT_W-1:0]             tot_wr_data,
    output logic [SMP_W-1:0]             inst_smp,
    output logic [SUM_W-AVG_SHIFT-1:0]   avg_pos,
    output logic [SUM_W-AVG_SHIFT-1:0]   avg_neg,
    output logic [TOT_W-1:0]             tot_pos,
    output logic [TOT_W-1:0]             tot_neg,
    output logic [SMP_W-1:0]             smp_min,
    output logic [SMP_W-1:0]             smp_max
);
    localparam int AVG_W = SUM_W - AVG_SHIFT;
    localparam int NCH   = 2;

    acc_state_e state_q, state_d;
    logic       take, latch_go, add_go;
    logic [SMP_W-1:0] mag   [NCH];
    logic [SUM_W-1:0] sum_q [NCH];
    logic [AVG_W-1:0] avg_q [NCH];
    logic [TOT_W-1:0] tot_q [NCH];
    logic             wr_ch [NCH];
    logic             add_ch[NCH];
    logic [AVG_W-1:0] add_b [NCH];

    assign take = cfg_en && smp_vld;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state and control strobes
    always_comb begin
        state_d  = state_q;
        latch_go = 1'b0;
        add_go   = 1'b0;
        unique case (state_q)
            ST_OFF:   state_d = ST_ACCUM;
            ST_ACCUM: if (sec_tick) state_d = ST_LATCH;
            ST_LATCH: begin
                latch_go = 1'b1;
                state_d  = ST_ADD;
            end
            ST_ADD: begin
                add_go  = 1'b1;
                state_d = ST_ACCUM;
            end
        endcase
        if (!cfg_en) state_d = ST_OFF;
    end

    adc_steer #(.SMP_W(SMP_W)) u_steer (
        .ofs     (cfg_ofs),
        .take    (take),
        .smp     (smp_data),
        .mag_pos (mag[0]),
        .mag_neg (mag[1])
    );

    adc_extrema #(.SMP_W(SMP_W)) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .smp    (smp_data),
        .last_q (inst_smp),
        .min_q  (smp_min),
        .max_q  (smp_max)
    );

    assign add_ch[0] = add_go && !cfg_stp;
    assign add_ch[1] = add_go && !cfg_stp && !cfg_grp;
    assign add_b[0]  = cfg_grp ? avg_q[1] : '0;
    assign add_b[1]  = '0;
    assign wr_ch[0]  = tot_wr_en && !tot_wr_sel;
    assign wr_ch[1]  = tot_wr_en && tot_wr_sel;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        adc_sec_sum #(.SMP_W(SMP_W), .SUM_W(SUM_W)) u_sum (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (cfg_en),
            .restart (latch_go),
            .add_val (mag[c]),
            .sum_q   (sum_q[c])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        avg_q[c] <= '0;
            else if (latch_go) avg_q[c] <= sum_q[c][SUM_W-1:AVG_SHIFT];
        end

        adc_total #(.AVG_W(AVG_W), .TOT_W(TOT_W)) u_tot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_ch[c]),
            .wr_data (tot_wr_data),
            .add_en  (add_ch[c]),
            .add_a   (avg_q[c]),
            .add_b   (add_b[c]),
            .tot_q   (tot_q[c])
        );
    end

    assign avg_pos = avg_q[0];
    assign avg_neg = avg_q[1];
    assign tot_pos = tot_q[0];
    assign tot_neg = tot_q[1];

    // R2: offset clear never grows the negative sum
    assert_neg_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ofs && state_q != ST_LATCH) |=> (sum_q[1] <= $past(sum_q[1])));

    // R4: averages move only on the cycle after a tick was taken
    assert_avg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LATCH) |=> (avg_pos == $past(avg_pos) && avg_neg == $past(avg_neg)));

    // R7: grouping leaves the negative total alone unless the host writes it
    assert_grp_neg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_grp && !(tot_wr_en && tot_wr_sel)) |=> $stable(tot_neg));

    // R8: stop freezes both totals apart from host writes
    assert_stop_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stp && !tot_wr_en) |=> ($stable(tot_pos) && $stable(tot_neg)));

    // R11: disabling clears both sums
    assert_off_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en) |=> (sum_q[0] == '0 && sum_q[1] == '0));

    // R12: a latch is always followed by the adding step (or shutdown), never another latch
    assert_tick_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH) |=> (state_q == ST_ADD || state_q == ST_OFF));
endmodule

// File: tb/sim_adc_avg_accum.sv
module sim_adc_avg_accum;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 0, cfg_ofs = 0, cfg_grp = 0, cfg_stp = 0;
    logic smp_vld = 0, sec_tick = 0, tot_wr_en = 0, tot_wr_sel = 0;
    logic [7:0]  smp_data = 0;
    logic [31:0] tot_wr_data = 0;
    logic [7:0]  inst_smp, smp_min, smp_max;
    logic [13:0] avg_pos, avg_neg;
    logic [31:0] tot_pos, tot_neg;

    always #5 clk = ~clk;

    adc_avg_accum u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ofs(cfg_ofs),
        .cfg_grp(cfg_grp), .cfg_stp(cfg_stp), .smp_vld(smp_vld),
        .smp_data(smp_data), .sec_tick(sec_tick), .tot_wr_en(tot_wr_en),
        .tot_wr_sel(tot_wr_sel), .tot_wr_data(tot_wr_data),
        .inst_smp(inst_smp), .avg_pos(avg_pos), .avg_neg(avg_neg),
        .tot_pos(tot_pos), .tot_neg(tot_neg), .smp_min(smp_min), .smp_max(smp_max)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit started = 0;
    string tag = "R1";

    // behavioural reference: 0 off, 1 summing, 2 closing, 3 adding
    int m_st = 0;
    longint m_s[2], m_a[2], m_t[2];
    int m_inst = 0, m_min = 255, m_max = 0;
    initial begin
        m_s[0] = 0; m_s[1] = 0; m_a[0] = 0; m_a[1] = 0; m_t[0] = 0; m_t[1] = 0;
    end

    always @(posedge clk) begin
        longint c[2];
        int nst;
        c[0] = 0; c[1] = 0;
        if (rst_n) begin
            if (cfg_en && smp_vld) begin
                int v;
                v = smp_data;
                if (!cfg_ofs) c[0] = v;
                else if (v > 128) c[0] = v - 128;
                else if (v < 128) c[1] = 128 - v;
                m_inst = v;
                if (v < m_min) m_min = v;
                if (v > m_max) m_max = v;
            end
            for (int k = 0; k < 2; k++) begin
                if (tot_wr_en && tot_wr_sel == k[0]) m_t[k] = tot_wr_data;
                else if (m_st == 3 && !cfg_stp) begin
                    if (k == 0) m_t[0] = (m_t[0] + m_a[0] + (cfg_grp ? m_a[1] : 0)) & 64'hFFFF_FFFF;
                    else if (!cfg_grp) m_t[1] = (m_t[1] + m_a[1]) & 64'hFFFF_FFFF;
                end
            end
            if (m_st == 2) begin m_a[0] = m_s[0] / 64; m_a[1] = m_s[1] / 64; end
            for (int k = 0; k < 2; k++) begin
                if (!cfg_en) m_s[k] = 0;
                else if (m_st == 2) m_s[k] = c[k];
                else begin
                    m_s[k] = m_s[k] + c[k];
                    if (m_s[k] > 1048575) m_s[k] = 1048575;
                end
            end
            case (m_st)
                0: nst = 1;
                1: nst = sec_tick ? 2 : 1;
                2: nst = 3;
                default: nst = 1;
            endcase
            m_st = cfg_en ? nst : 0;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (started) begin
            checks++;
            if (avg_pos !== 14'(m_a[0]) || avg_neg !== 14'(m_a[1]) ||
                tot_pos !== 32'(m_t[0]) || tot_neg !== 32'(m_t[1]) ||
                inst_smp !== 8'(m_inst) || smp_min !== 8'(m_min) || smp_max !== 8'(m_max)) begin
                errors++;
                $display("FAIL %s cycle %0d: actual avg=%0d/%0d tot=%h/%h inst=%0d min=%0d max=%0d expected avg=%0d/%0d tot=%h/%h inst=%0d min=%0d max=%0d",
                    tag, cycles, avg_pos, avg_neg, tot_pos, tot_neg, inst_smp, smp_min, smp_max,
                    m_a[0], m_a[1], m_t[0], m_t[1], m_inst, m_min, m_max);
            end
        end
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string t, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input int d, input bit tk);
        @(negedge clk);
        smp_vld = v; smp_data = 8'(d); sec_tick = tk; tot_wr_en = 0;
    endtask

    task automatic signed_set(input int reps);
        for (int r = 0; r < reps; r++) begin
            cyc(1, 0, 0); cyc(1, 128, 0); cyc(1, 255, 0); cyc(1, 100, 0); cyc(1, 200, 0);
        end
    endtask

    task automatic close_second();
        cyc(0, 0, 1);
        cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    endtask

    task automatic host_wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        smp_vld = 0; sec_tick = 0; tot_wr_en = 1; tot_wr_sel = sel; tot_wr_data = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        started = 1;
        @(negedge clk);
        chk("R1 tot_pos", tot_pos, 0);
        chk("R1 min", smp_min, 255);
        chk("R1 max", smp_max, 0);

        tag = "R2"; cfg_en = 1;
        cyc(1, 10, 0); cyc(1, 200, 0); cyc(1, 255, 0);
        tag = "R4"; close_second();
        chk("R4 avg_pos", avg_pos, 7);
        chk("R6 tot_pos", tot_pos, 7);
        chk("R10 min", smp_min, 10);
        chk("R10 max", smp_max, 255);

        tag = "R5";
        for (int i = 0; i < 4200; i++) cyc(1, 255, 0);
        close_second();
        chk("R5 avg_pos", avg_pos, 16383);
        chk("R5 tot_pos", tot_pos, 16390);

        tag = "R3"; cfg_ofs = 1;
        signed_set(20); close_second();
        chk("R3 avg_pos", avg_pos, 62);
        chk("R3 avg_neg", avg_neg, 48);
        chk("R3 tot_neg", tot_neg, 48);

        tag = "R7"; cfg_grp = 1;
        signed_set(20); close_second();
        chk("R7 tot_pos", tot_pos, 16562);
        chk("R7 tot_neg", tot_neg, 48);

        tag = "R8"; cfg_grp = 0; cfg_stp = 1;
        signed_set(10); close_second();
        chk("R8 avg_pos", avg_pos, 31);
        chk("R8 tot_pos", tot_pos, 16562);

        tag = "R9"; cfg_stp = 0;
        host_wr(0, 32'hFFFF_FFF0); host_wr(1, 32'd5);
        signed_set(20); close_second();
        chk("R6 wrap tot_pos", tot_pos, 46);
        chk("R9 tot_neg", tot_neg, 53);
        signed_set(20);
        cyc(0, 0, 1); cyc(0, 0, 0); host_wr(1, 32'd1000);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R9 priority tot_neg", tot_neg, 1000);
        chk("R9 tot_pos", tot_pos, 108);

        tag = "R12";
        signed_set(20);
        cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R12 tot_pos", tot_pos, 170);

        tag = "R11"; cfg_en = 0;
        cyc(1, 7, 0); cyc(1, 7, 1); cyc(1, 7, 0);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R11 inst", inst_smp, 200);
        chk("R11 avg_pos", avg_pos, 62);
        chk("R11 tot_pos", tot_pos, 170);
        chk("R10 final min", smp_min, 0);
        chk("R10 final max", smp_max, 255);

        cyc(0, 0, 0);
        started = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule